// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block carries out one flash command at a time over a single serial data lane. Software places a packed 32-bit command word, an address and up to eight bytes of write data on the inputs, then writes the command word with its execute bit set. The block then clocks the command out one bit per clock cycle. It sends an opcode, an optional address of one to four bytes and an optional run of dummy cycles. It then either sends up to eight data bytes or receives up to eight data bytes.

While the command runs, a busy flag (the in-progress indication) stays high. Received bytes are gathered into two 32-bit read words, which change only when a read command finishes. The serial side drives a select line, a bit strobe that is high for each transferred bit, and a data-out line, and it samples a data-in line on strobe cycles. The shifter or pad logic that turns the strobe into an actual serial clock sits outside the block.

Top module: `flash_cmd_seq`

## Requirements
- R1: Command word layout: opcode in bits 31:24, receive enable in bit 23, receive count minus one in bits 22:20, address enable in bit 19, address count minus one in bits 17:16, send enable in bit 15, send count minus one in bits 14:12, dummy cycle count in bits 11:7, execute in bit 0. Bits 18 and 6:1 are ignored.
- R2: A write to the command word with bit 0 set while idle starts a command. Busy is high from the next cycle for exactly 8 + 8·A + D + 8·N cycles, where A is the address byte count (0 when disabled), D is the dummy count and N is the byte count of the data phase that runs (0 if none). Busy then returns low.
- R3: While busy, cs_n is 0 and sck_en is 1, and one bit moves per cycle. While idle, cs_n is 1 and sck_en is 0.
- R4: The opcode goes first, most significant bit first.
- R5: When address is enabled, A bytes come from the low 8·A bits of the address input, most significant byte first. With A = 4 all 32 bits are sent.
- R6: Dummy cycles follow the address, number D, and carry mosi = 0. D = 0 means no dummy phase.
- R7: When sending, N bytes follow. Byte k is bits 8k+7:8k of {wdata_hi, wdata_lo}, with byte 0 first and each byte MSB first.
- R8: When receiving, N bytes are sampled from miso on strobe cycles, MSB first, while mosi is 0. Byte k lands in bits 8k+7:8k of {rdata_hi, rdata_lo}, and bytes at or above N read as 0. The read words take the new value in the cycle busy falls.
- R9: The read words keep their value except at the end of a receive command.
- R10: While busy, a new execute write, and any change of the command word, address or write data, has no effect on the running command.
- R11: With both send and receive enabled, the write bytes are sent, no receive phase runs and the read words are unchanged.
- R12: After reset: busy 0, cs_n 1, sck_en 0, mosi 0, read words 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Command word write strobe |
| ctrl_word | input | 32 | Packed command word (bit 0 = execute) |
| addr_word | input | 32 | Flash address, sampled at start |
| wdata_lo | input | 32 | Write bytes 0..3, sampled at start |
| wdata_hi | input | 32 | Write bytes 4..7, sampled at start |
| busy | output | 1 | Command in progress |
| rdata_lo | output | 32 | Received bytes 0..3 |
| rdata_hi | output | 32 | Received bytes 4..7 |
| cs_n | output | 1 | Flash select, active low |
| sck_en | output | 1 | Bit strobe, one bit per high cycle |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |

## Verification
The assertions assume the command word is written at most once per cycle. They also assume miso is settled ahead of the clock edge in each strobe cycle, because every received bit is taken on that edge. The bench changes miso only at falling edges and holds ctrl_wr for a single cycle. It also deliberately issues stray execute writes, with scrambled address and write data, in the middle of running commands, which is the one input pattern the design must tolerate rather than be shielded from.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam int ADDR_BYTES_MAX = 4;
    localparam int DATA_BYTES_MAX = 8;
    localparam int ADDR_W         = 8 * ADDR_BYTES_MAX;
    localparam int DATA_W         = 8 * DATA_BYTES_MAX;
    localparam int IDX_W          = $clog2(DATA_BYTES_MAX);
    localparam int ACNT_W         = $clog2(ADDR_BYTES_MAX);
    localparam int DUMMY_W        = 5;
    localparam int CNT_W          = DUMMY_W;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_OPC   = 3'd1,
        PH_ADDR  = 3'd2,
        PH_DUMMY = 3'd3,
        PH_WDATA = 3'd4,
        PH_RDATA = 3'd5
    } phase_e;

    typedef struct packed {
        logic [7:0]         opcode;
        logic               rd_en;
        logic [IDX_W-1:0]   rd_n;
        logic               addr_en;
        logic [ACNT_W-1:0]  addr_n;
        logic               wr_en;
        logic [IDX_W-1:0]   wr_n;
        logic [DUMMY_W-1:0] dummy;
    } cmd_t;

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   cnt;
        logic [IDX_W-1:0]   idx;
        logic [7:0]         sh;
        cmd_t               cmd;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  wdata;
        logic [DATA_W-1:0]  rxbuf;
        logic [DATA_W-1:0]  rdata;
    } seq_t;

    // Phase that follows cur; empty phases are skipped, send wins over receive.
    function automatic phase_e next_phase(input phase_e cur, input cmd_t c);
        logic try_addr;
        logic try_dummy;
        logic try_data;
        phase_e res;
        try_addr  = (cur == PH_OPC);
        try_dummy = try_addr || (cur == PH_ADDR);
        try_data  = try_dummy || (cur == PH_DUMMY);
        if (try_addr && c.addr_en)                  res = PH_ADDR;
        else if (try_dummy && (c.dummy != '0))      res = PH_DUMMY;
        else if (try_data && c.wr_en)               res = PH_WDATA;
        else if (try_data && c.rd_en)               res = PH_RDATA;
        else                                        res = PH_IDLE;
        return res;
    endfunction

    // Index of the final byte of a phase.
    function automatic logic [IDX_W-1:0] phase_last(input phase_e ph, input cmd_t c);
        logic [IDX_W-1:0] res;
        case (ph)
            PH_ADDR:  res = IDX_W'(c.addr_n);
            PH_WDATA: res = c.wr_n;
            PH_RDATA: res = c.rd_n;
            default:  res = '0;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/fcs_decode.sv
module fcs_decode
    import flash_seq_pkg::*;
(
    input  logic [31:0] word,
    output cmd_t        cmd
);
    logic unused_bits;

    always_comb begin
        cmd.opcode  = word[31:24];
        cmd.rd_en   = word[23];
        cmd.rd_n    = word[22:20];
        cmd.addr_en = word[19];
        cmd.addr_n  = word[17:16];
        cmd.wr_en   = word[15];
        cmd.wr_n    = word[14:12];
        cmd.dummy   = word[11:7];
    end

    assign unused_bits = ^{word[18], word[6:0]};

endmodule

// File: rtl/fcs_byte_sel.sv
module fcs_byte_sel
    import flash_seq_pkg::*;
(
    input  phase_e             phase,
    input  logic [IDX_W-1:0]   idx,
    input  logic [7:0]         opcode,
    input  logic [ACNT_W-1:0]  addr_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [7:0]         tx_byte
);
    logic [IDX_W-1:0]  addr_pos;

    // Address goes out high byte first: byte idx is (addr_n - idx) from the bottom.
    assign addr_pos = IDX_W'(addr_n) - idx;

    always_comb begin
        case (phase)
            PH_OPC:   tx_byte = opcode;
            PH_ADDR:  tx_byte = addr[{addr_pos[ACNT_W-1:0], 3'b000} +: 8];
            PH_WDATA: tx_byte = wdata[{idx, 3'b000} +: 8];
            default:  tx_byte = 8'h00;
        endcase
    end

endmodule

// File: rtl/fcs_seq.sv
module fcs_seq
    import flash_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  cmd_t               dec_cmd,
    input  logic [ADDR_W-1:0]  addr_in,
    input  logic [DATA_W-1:0]  wdata_in,
    input  logic               miso,
    output logic               busy,
    output logic               mosi,
    output logic [DATA_W-1:0]  rdata
);
    seq_t              q;
    seq_t              d;
    phase_e            nxt_ph;
    phase_e            sel_ph;
    logic [IDX_W-1:0]  sel_idx;
    logic              last_byte;
    logic              last_bit;
    logic [7:0]        sel_byte;
    logic [7:0]        shifted;

    always_comb begin
        nxt_ph    = next_phase(q.phase, q.cmd);
        last_byte = (q.idx == phase_last(q.phase, q.cmd));
        last_bit  = (q.cnt == CNT_W'(1));
        sel_ph    = q.phase;
        sel_idx   = q.idx + IDX_W'(1);
        if (last_byte) begin
            sel_ph  = nxt_ph;
            sel_idx = '0;
        end
    end

    fcs_byte_sel u_sel (
        .phase   (sel_ph),
        .idx     (sel_idx),
        .opcode  (q.cmd.opcode),
        .addr_n  (q.cmd.addr_n),
        .addr    (q.addr),
        .wdata   (q.wdata),
        .tx_byte (sel_byte)
    );

    assign shifted = {q.sh[6:0], miso};

    always_comb begin
        d = q;
        if (q.phase == PH_IDLE) begin
            if (start) begin
                d.cmd   = dec_cmd;
                d.addr  = addr_in;
                d.wdata = wdata_in;
                d.rxbuf = '0;
                d.phase = PH_OPC;
                d.cnt   = CNT_W'(8);
                d.idx   = '0;
                d.sh    = dec_cmd.opcode;
            end
        end else if (last_bit) begin
            if (q.phase == PH_RDATA) begin
                d.rxbuf[{q.idx, 3'b000} +: 8] = shifted;
            end
            if (!last_byte) begin
                d.idx = q.idx + IDX_W'(1);
                d.cnt = CNT_W'(8);
                d.sh  = sel_byte;
            end else begin
                d.phase = nxt_ph;
                d.idx   = '0;
                d.cnt   = (nxt_ph == PH_DUMMY) ? q.cmd.dummy : CNT_W'(8);
                d.sh    = sel_byte;
                if (nxt_ph == PH_IDLE && q.cmd.rd_en && !q.cmd.wr_en) begin
                    d.rdata = d.rxbuf;
                end
            end
        end else begin
            d.cnt = q.cnt - CNT_W'(1);
            d.sh  = shifted;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy  = (q.phase != PH_IDLE);
    assign mosi  = q.sh[7] && (q.phase == PH_OPC || q.phase == PH_ADDR || q.phase == PH_WDATA);
    assign rdata = q.rdata;

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_wr,
    input  logic [31:0] ctrl_word,
    input  logic [31:0] addr_word,
    input  logic [31:0] wdata_lo,
    input  logic [31:0] wdata_hi,
    output logic        busy,
    output logic [31:0] rdata_lo,
    output logic [31:0] rdata_hi,
    output logic        cs_n,
    output logic        sck_en,
    output logic        mosi,
    input  logic        miso
);
    cmd_t              dec_cmd;
    logic              start;
    logic [DATA_W-1:0] rdata;

    fcs_decode u_dec (
        .word (ctrl_word),
        .cmd  (dec_cmd)
    );

    assign start = ctrl_wr && ctrl_word[0];

    fcs_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .dec_cmd  (dec_cmd),
        .addr_in  (addr_word),
        .wdata_in ({wdata_hi, wdata_lo}),
        .miso     (miso),
        .busy     (busy),
        .mosi     (mosi),
        .rdata    (rdata)
    );

    assign cs_n     = !busy;
    assign sck_en   = busy;
    assign rdata_lo = rdata[31:0];
    assign rdata_hi = rdata[63:32];

endmodule

// File: rtl/fcs_seq_chk.sv
module fcs_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ctrl_wr,
    input logic [31:0] ctrl_word,
    input logic        busy,
    input logic        mosi,
    input logic [31:0] rdata_lo,
    input logic [31:0] rdata_hi
);
    logic [7:0] run_len;
    logic       unused_chk;

    assign unused_chk = ^ctrl_word[30:1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 run_len <= '0;
        else if (!busy)             run_len <= '0;
        else if (run_len != 8'hFF)  run_len <= run_len + 8'd1;
    end

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_word[0] && !busy) |=> busy);

    assert_rise_by_exec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ctrl_wr && ctrl_word[0]));

    assert_opcode_msb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mosi == $past(ctrl_word[31])));

    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(busy) |-> ($stable(rdata_lo) && $stable(rdata_hi)));

    assert_min_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len >= 8'd8));

endmodule

bind flash_cmd_seq fcs_seq_chk u_chk (.*);

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [31:0] ctrl_word = '0;
    logic [31:0] addr_word = '0;
    logic [31:0] wdata_lo = '0;
    logic [31:0] wdata_hi = '0;
    logic        miso = 1'b0;
    logic        busy;
    logic [31:0] rdata_lo;
    logic [31:0] rdata_hi;
    logic        cs_n;
    logic        sck_en;
    logic        mosi;

    int          nchk = 0;
    int          nerr = 0;
    logic        done = 1'b0;
    logic [63:0] exp_rd = '0;

    always #5 clk = ~clk;

    flash_cmd_seq u_flash_cmd_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .ctrl_word (ctrl_word),
        .addr_word (addr_word),
        .wdata_lo  (wdata_lo),
        .wdata_hi  (wdata_hi),
        .busy      (busy),
        .rdata_lo  (rdata_lo),
        .rdata_hi  (rdata_hi),
        .cs_n      (cs_n),
        .sck_en    (sck_en),
        .mosi      (mosi),
        .miso      (miso)
    );

    task automatic chk(input logic ok, input string rq, input logic [63:0] act, input logic [63:0] expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", rq, act, expv);
        end
    endtask

    function automatic string req_name(input int k);
        case (k)
            4:       return "R4 opcode bit";
            5:       return "R5 address bit";
            6:       return "R6 dummy bit";
            7:       return "R7 write bit";
            default: return "R8 read phase mosi";
        endcase
    endfunction

    // R1 field packing, built independently of the design.
    function automatic logic [31:0] mk(input logic [7:0] op, input logic rd, input int rn,
                                       input logic ae, input int an, input logic we,
                                       input int wn, input int dm);
        logic [31:0] w;
        w = '0;
        w[31:24] = op;
        w[23]    = rd;
        w[22:20] = 3'(rn - 1);
        w[19]    = ae;
        w[17:16] = 2'(an - 1);
        w[15]    = we;
        w[14:12] = 3'(wn - 1);
        w[11:7]  = 5'(dm);
        return w;
    endfunction

    task automatic run_cmd(input logic [31:0] cw, input logic [31:0] addr,
                           input logic [63:0] wd, input logic [63:0] rpat,
                           input logic poke, input string rq);
        logic       ebit  [0:199];
        int         ekind [0:199];
        int         rdix  [0:199];
        int         n;
        int         an;
        int         rn;
        int         wn;
        logic [7:0] b;
        n  = 0;
        an = int'(cw[17:16]) + 1;
        rn = int'(cw[22:20]) + 1;
        wn = int'(cw[14:12]) + 1;
        for (int j = 0; j < 8; j++) begin
            ebit[n] = cw[31-j]; ekind[n] = 4; rdix[n] = -1; n++;
        end
        if (cw[19]) begin
            for (int m = 0; m < an; m++) begin
                b = 8'(addr >> (8 * (an - 1 - m)));
                for (int j = 0; j < 8; j++) begin
                    ebit[n] = b[7-j]; ekind[n] = 5; rdix[n] = -1; n++;
                end
            end
        end
        for (int j = 0; j < int'(cw[11:7]); j++) begin
            ebit[n] = 1'b0; ekind[n] = 6; rdix[n] = -1; n++;
        end
        if (cw[15]) begin
            for (int m = 0; m < wn; m++) begin
                b = wd[8*m +: 8];
                for (int j = 0; j < 8; j++) begin
                    ebit[n] = b[7-j]; ekind[n] = 7; rdix[n] = -1; n++;
                end
            end
        end else if (cw[23]) begin
            for (int m = 0; m < rn; m++) begin
                for (int j = 0; j < 8; j++) begin
                    ebit[n] = 1'b0; ekind[n] = 8; rdix[n] = 8*m + 7 - j; n++;
                end
            end
        end

        @(negedge clk);
        ctrl_word = cw | 32'h1;
        ctrl_wr   = 1'b1;
        addr_word = addr;
        wdata_lo  = wd[31:0];
        wdata_hi  = wd[63:32];
        @(negedge clk);
        ctrl_wr   = 1'b0;
        // R10: inputs scrambled once the command is under way
        ctrl_word = $urandom;
        addr_word = $urandom;
        wdata_lo  = $urandom;
        wdata_hi  = $urandom;
        for (int i = 0; i < n; i++) begin
            miso = (rdix[i] >= 0) ? rpat[rdix[i]] : 1'($urandom);
            chk(busy && !cs_n && sck_en, "R3 busy/cs_n/sck_en during command",
                {61'd0, busy, cs_n, sck_en}, 64'h5);
            chk(mosi == ebit[i], req_name(ekind[i]), {63'd0, mosi}, {63'd0, ebit[i]});
            if (poke && i == 2) begin
                ctrl_wr   = 1'b1;
                ctrl_word = $urandom | 32'h1;
            end else begin
                ctrl_wr   = 1'b0;
            end
            @(negedge clk);
        end
        ctrl_wr = 1'b0;
        chk(!busy && cs_n && !sck_en, "R2 busy length / R3 idle lines",
            {61'd0, busy, cs_n, sck_en}, 64'h2);
        if (cw[23] && !cw[15]) begin
            exp_rd = '0;
            for (int m = 0; m < rn; m++) exp_rd[8*m +: 8] = rpat[8*m +: 8];
        end
        chk({rdata_hi, rdata_lo} == exp_rd, rq, {rdata_hi, rdata_lo}, exp_rd);
        if (poke) chk(!busy, "R10 stray execute while busy ignored", {63'd0, busy}, 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!busy && cs_n && !sck_en && !mosi, "R12 reset lines",
            {60'd0, busy, cs_n, sck_en, mosi}, 64'h4);
        chk({rdata_hi, rdata_lo} == 64'd0, "R12 reset read words", {rdata_hi, rdata_lo}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 full-field read: 4-byte address, 31 dummies, 8 bytes in
        run_cmd(mk(8'hEB, 1, 8, 1, 4, 0, 1, 31), 32'hA1B2C3D4, 64'd0,
                64'h0123456789ABCDEF, 1'b0, "R1 R8 full read");
        // opcode only: read words untouched
        run_cmd(mk(8'h06, 0, 1, 0, 1, 0, 1, 0), 32'h0, 64'd0, 64'd0, 1'b0, "R9 opcode only");
        // R5 3-byte address, 8 write bytes
        run_cmd(mk(8'h02, 0, 1, 1, 3, 1, 8, 0), 32'hFF123456, 64'hDEADBEEF_CAFEF00D,
                64'd0, 1'b0, "R7 R9 write keeps read words");
        // 1-byte address, 1 read byte: upper bytes clear
        run_cmd(mk(8'h9F, 1, 1, 1, 1, 0, 1, 1), 32'h000000A5, 64'd0,
                64'hFFFFFFFF_FFFFFF3C, 1'b0, "R8 single byte, rest zero");
        // R11 both enables
        run_cmd(mk(8'h31, 1, 4, 0, 1, 1, 2, 8), 32'h0, 64'h0000_0000_0000_5AA5,
                64'h1111_2222_3333_4444, 1'b0, "R11 send wins, read words kept");
        // R10 stray execute during a read
        run_cmd(mk(8'h0B, 1, 5, 1, 3, 0, 1, 8), 32'h00ABCDEF, 64'd0,
                64'h00FE_DCBA_9876_5432, 1'b1, "R10 R8 read under poke");

        for (int t = 0; t < 150; t++) begin
            run_cmd($urandom, $urandom, {$urandom, $urandom}, {$urandom, $urandom},
                    1'($urandom % 4 == 0), "R8 R9 random read words");
            if (t % 7 == 0) repeat (1 + $urandom % 3) @(negedge clk);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule